// File: doc/BRIEF.md
# Circular Reply Address Generator

This block turns reply requests into pairs of bus write requests aimed at a small ring of reply slots in host memory. The host first programs a 32-bit base address in two 16-bit halves: the upper half is staged by one strobe, and the lower half commits the whole base. From then on, every accepted reply occupies an 8-byte slot. The slot holds a fixed header word (source 1, destination 0, word count 2) followed by the 24-bit payload, zero-extended to 32 bits.

The slot offset steps by 8 bytes through a 128-byte window and then returns to the base. Only the low 16 address bits are ever incremented, so the upper half of the address never changes while the ring is in use. Until a base has been committed since reset, requests are still accepted but no write is produced. When the interrupt option is on, an interrupt request at level 5 with vector byte 0xF0 is raised after each reply and held until it is acknowledged. Bus arbitration and the electrical bus handshake are handled outside this block.

Top module: `reply_ring_gen`

## Requirements
- R1: A pulse on `lo_ld` commits the base as {most recently staged upper half, `base_half`}. A pulse on `hi_ld` alone changes no address used by later replies.
- R2: The first reply accepted after a commit is written at offset 0 from the new base, wherever the ring stood before the commit.
- R3: Each further reply starts 8 bytes after the start of the previous reply.
- R4: After the slot at offset 120, the next reply is written at offset 0 (16 slots per ring).
- R5: Bits 31:16 of every write address equal the committed upper half. Bits 15:0 equal (lower half + offset + 4·word) modulo 65536, so a carry never reaches the upper half.
- R6: While `armed` is 0 (no commit since reset), requests are accepted and discarded and `wr_valid` stays 0. `armed` goes to 1 in the cycle after the first commit.
- R7: A reply is two writes, in this order: header 0x00010002 at the slot address, then {8'h00, payload} at slot address + 4. Each write keeps its address and data until `wr_ready` is seen.
- R8: `req_ready` is 0 while either write of a reply is outstanding, and 1 otherwise.
- R9: With `irq_en` at 1 when the payload write completes, `irq_req` rises in the next cycle with `irq_vec` = 0xF0 and `irq_level` = 5, and stays at 1 until `irq_ack` is seen.
- R10: With `irq_en` at 0, a completed reply does not raise `irq_req`.
- R11: If a reply is accepted in the same cycle as a commit, that reply goes to the new base at offset 0, and the next reply goes to offset 8.
- R12: After reset, `req_ready` = 1, `wr_valid` = 0, `irq_req` = 0 and `armed` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_ld | input | 1 | Stage `base_half` as the upper address half |
| lo_ld | input | 1 | Commit the base using `base_half` as the lower half |
| base_half | input | 16 | Address half value for either strobe |
| req_valid | input | 1 | Reply request |
| req_ready | output | 1 | Request is taken when this and `req_valid` are both high |
| req_payload | input | 24 | Payload word of the reply |
| irq_en | input | 1 | Interrupt option |
| wr_valid | output | 1 | Write request to the bus |
| wr_ready | input | 1 | Write accepted by the bus |
| wr_addr | output | 32 | Write byte address |
| wr_data | output | 32 | Write data |
| irq_req | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_vec | output | 8 | Interrupt vector byte |
| irq_level | output | 3 | Interrupt level |
| armed | output | 1 | A base has been committed since reset |

## Verification
Two functions can fall in the same cycle: a base commit on `lo_ld` and the acceptance of a reply request. The bench provokes this by waiting until the block is idle and then raising `lo_ld` and `req_valid` on the same edge. A scoreboard expects the header at the new base and the payload at base+4, and expects the following reply at base+8. Both the old ring position and the old base must therefore be ignored. A second overlap, a completing payload write in the same cycle as the interrupt enable being sampled, is judged by checking `irq_req` in the cycle after the write drains.

// File: rtl/rag_pkg.sv
package rag_pkg;

  localparam int HALF_W = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_HDR  = 2'd1,
    PH_PAY  = 2'd2
  } phase_e;

  // Low address half of a slot: only the low half ever carries.
  function automatic logic [HALF_W-1:0] slot_low(input logic [HALF_W-1:0] lo,
                                                  input logic [HALF_W-1:0] off);
    return lo + off;
  endfunction

  // Next ring offset: step by the slot size, fold to zero at the ring size.
  function automatic int unsigned ring_step(input int unsigned off,
                                            input int unsigned slot,
                                            input int unsigned ring);
    return ((off + slot) >= ring) ? 0 : (off + slot);
  endfunction

endpackage

// File: rtl/rag_base_reg.sv
module rag_base_reg #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hi_ld,
  input  logic              lo_ld,
  input  logic [HALF_W-1:0] base_half,
  output logic [HALF_W-1:0] eff_hi,
  output logic [HALF_W-1:0] eff_lo,
  output logic              eff_armed,
  output logic              armed_q,
  output logic              commit
);
  logic [HALF_W-1:0] hi_stage_q;
  logic [HALF_W-1:0] hi_q;
  logic [HALF_W-1:0] lo_q;

  assign commit    = lo_ld;
  assign eff_hi    = commit ? hi_stage_q : hi_q;
  assign eff_lo    = commit ? base_half  : lo_q;
  assign eff_armed = commit | armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_stage_q <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      armed_q    <= 1'b0;
    end else begin
      if (hi_ld) hi_stage_q <= base_half;
      if (commit) begin
        hi_q    <= hi_stage_q;
        lo_q    <= base_half;
        armed_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rag_slot_ptr.sv
module rag_slot_ptr #(
  parameter int SLOT_BYTES = 8,
  parameter int RING_BYTES = 128,
  parameter int OFF_W      = $clog2(RING_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic             take,
  output logic [OFF_W-1:0] eff_off
);
  logic [OFF_W-1:0] off_q;
  logic [OFF_W-1:0] off_next;

  assign eff_off  = commit ? '0 : off_q;
  assign off_next = OFF_W'(rag_pkg::ring_step(int'(eff_off), SLOT_BYTES, RING_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (take)   off_q <= off_next;
    else if (commit) off_q <= '0;
  end
endmodule

// File: rtl/rag_write_seq.sv
module rag_write_seq #(
  parameter int HALF_W     = 16,
  parameter int DATA_W     = 32,
  parameter int PAY_W      = 24,
  parameter int WORD_BYTES = 4,
  parameter logic [DATA_W-1:0] HDR_WORD = 32'h0001_0002
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [PAY_W-1:0]     req_payload,
  input  logic                 eff_armed,
  input  logic [HALF_W-1:0]    eff_hi,
  input  logic [HALF_W-1:0]    slot_lo,
  input  logic                 wr_ready,
  output logic                 req_ready,
  output logic                 take,
  output logic                 wr_valid,
  output logic [2*HALF_W-1:0]  wr_addr,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 done,
  output rag_pkg::phase_e      phase
);
  import rag_pkg::*;

  logic [HALF_W-1:0] hi_q;
  logic [HALF_W-1:0] lo_q;
  logic [PAY_W-1:0]  pay_q;

  assign req_ready = (phase == PH_IDLE);
  assign take      = req_valid && req_ready && eff_armed;
  assign wr_valid  = (phase != PH_IDLE);
  assign done      = (phase == PH_PAY) && wr_ready;

  always_comb begin
    if (phase == PH_PAY) begin
      wr_addr = {hi_q, slot_low(lo_q, HALF_W'(WORD_BYTES))};
      wr_data = {{(DATA_W-PAY_W){1'b0}}, pay_q};
    end else begin
      wr_addr = {hi_q, lo_q};
      wr_data = HDR_WORD;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      hi_q  <= '0;
      lo_q  <= '0;
      pay_q <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (take) begin
          phase <= PH_HDR;
          hi_q  <= eff_hi;
          lo_q  <= slot_lo;
          pay_q <= req_payload;
        end
        PH_HDR:  if (wr_ready) phase <= PH_PAY;
        PH_PAY:  if (wr_ready) phase <= PH_IDLE;
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rag_irq.sv
module rag_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic done,
  input  logic irq_en,
  input  logic irq_ack,
  output logic irq_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                irq_req <= 1'b0;
    else if (done && irq_en)   irq_req <= 1'b1;
    else if (irq_ack)          irq_req <= 1'b0;
  end
endmodule

// File: rtl/reply_ring_gen.sv
module reply_ring_gen #(
  parameter int HALF_W     = rag_pkg::HALF_W,
  parameter int DATA_W     = 32,
  parameter int PAY_W      = 24,
  parameter int WORD_BYTES = 4,
  parameter int SLOT_BYTES = 8,
  parameter int RING_BYTES = 128,
  parameter logic [DATA_W-1:0] HDR_WORD = 32'h0001_0002,
  parameter logic [7:0] IRQ_VECTOR = 8'hF0,
  parameter logic [2:0] IRQ_PRIO   = 3'd5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hi_ld,
  input  logic                lo_ld,
  input  logic [HALF_W-1:0]   base_half,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [PAY_W-1:0]    req_payload,
  input  logic                irq_en,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [2*HALF_W-1:0] wr_addr,
  output logic [DATA_W-1:0]   wr_data,
  output logic                irq_req,
  input  logic                irq_ack,
  output logic [7:0]          irq_vec,
  output logic [2:0]          irq_level,
  output logic                armed
);
  localparam int OFF_W = $clog2(RING_BYTES);

  logic [HALF_W-1:0] eff_hi;
  logic [HALF_W-1:0] eff_lo;
  logic              eff_armed;
  logic              commit;
  logic              take;
  logic              done;
  logic [OFF_W-1:0]  eff_off;
  logic [HALF_W-1:0] slot_lo;
  rag_pkg::phase_e   phase;

  rag_base_reg #(.HALF_W(HALF_W)) u_base (
    .clk(clk), .rst_n(rst_n), .hi_ld(hi_ld), .lo_ld(lo_ld),
    .base_half(base_half), .eff_hi(eff_hi), .eff_lo(eff_lo),
    .eff_armed(eff_armed), .armed_q(armed), .commit(commit)
  );

  rag_slot_ptr #(.SLOT_BYTES(SLOT_BYTES), .RING_BYTES(RING_BYTES), .OFF_W(OFF_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .take(take), .eff_off(eff_off)
  );

  assign slot_lo = rag_pkg::slot_low(eff_lo, HALF_W'(eff_off));

  rag_write_seq #(
    .HALF_W(HALF_W), .DATA_W(DATA_W), .PAY_W(PAY_W),
    .WORD_BYTES(WORD_BYTES), .HDR_WORD(HDR_WORD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_payload(req_payload),
    .eff_armed(eff_armed), .eff_hi(eff_hi), .slot_lo(slot_lo),
    .wr_ready(wr_ready), .req_ready(req_ready), .take(take),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .phase(phase)
  );

  rag_irq u_irq (
    .clk(clk), .rst_n(rst_n), .done(done), .irq_en(irq_en),
    .irq_ack(irq_ack), .irq_req(irq_req)
  );

  assign irq_vec   = IRQ_VECTOR;
  assign irq_level = IRQ_PRIO;
endmodule

module reply_ring_gen_chk #(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [AW-1:0]   wr_addr,
  input logic [DW-1:0]   wr_data,
  input logic            armed,
  input logic            irq_req,
  input logic            irq_ack,
  input logic            irq_en,
  input logic            done,
  input rag_pkg::phase_e phase
);
  a_r8_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !req_ready);

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r7_word_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && phase == rag_pkg::PH_HDR) |=>
      (wr_valid && wr_addr[AW/2-1:0] == $past(wr_addr[AW/2-1:0]) + 4'd4
       && wr_addr[AW-1:AW/2] == $past(wr_addr[AW-1:AW/2])));

  a_r6_silent: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !wr_valid);

  a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (done && irq_en) |=> irq_req);

  a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && !irq_ack) |=> irq_req);

  a_r10_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && !irq_req) |=> !irq_req);
endmodule

bind reply_ring_gen reply_ring_gen_chk #(.AW(2*HALF_W), .DW(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data), .armed(armed),
  .irq_req(irq_req), .irq_ack(irq_ack), .irq_en(irq_en), .done(done),
  .phase(phase)
);

// File: tb/sim_reply_ring_gen.sv
`timescale 1ns/1ps
module sim_reply_ring_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hi_ld = 1'b0, lo_ld = 1'b0;
  logic [15:0] base_half = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_payload = '0;
  logic        irq_en = 1'b0;
  logic        wr_valid;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr, wr_data;
  logic        irq_req;
  logic        irq_ack = 1'b0;
  logic [7:0]  irq_vec;
  logic [2:0]  irq_level;
  logic        armed;

  int errors = 0, checks = 0, writes_seen = 0, cyc = 0;
  bit stall_mode = 0;
  string tag = "R7";
  logic [63:0] exp_q[$];

  // bench-side model of the ring
  logic [15:0] m_stage = '0, m_hi = '0, m_lo = '0;
  int unsigned m_off = 0;
  bit m_armed = 0;

  always #4 clk = ~clk;

  reply_ring_gen u0 (.*);

  always @(posedge clk) begin
    cyc++;
    #1 wr_ready = stall_mode ? (cyc % 3 != 0) : 1'b1;
  end

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each completed write
  always @(negedge clk) begin
    if (rst_n && wr_valid && wr_ready) begin
      writes_seen++;
      check(req_ready == 1'b0, "R8", "ready during write", {63'd0, req_ready}, 64'd0);
      if (exp_q.size() == 0)
        check(1'b0, "R6", "unexpected write", {wr_addr, wr_data}, 64'd0);
      else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check({wr_addr, wr_data} == e, tag, "write addr/data", {wr_addr, wr_data}, e);
      end
    end
  end

  function automatic logic [15:0] lo_of(input int unsigned off, input int unsigned w);
    return m_lo + 16'(off) + 16'(w);
  endfunction

  task automatic push_expected(input logic [23:0] p);
    if (m_armed) begin
      exp_q.push_back({m_hi, lo_of(m_off, 0), 32'h0001_0002});
      exp_q.push_back({m_hi, lo_of(m_off, 4), 8'h00, p});
      m_off = (m_off + 8 >= 128) ? 0 : m_off + 8;
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && (exp_q.size() != 0 || wr_valid); i++) @(negedge clk);
  endtask

  task automatic send_reply(input logic [23:0] p);
    @(posedge clk); #1;
    req_valid = 1'b1; req_payload = p;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    push_expected(p);
    @(posedge clk); #1 req_valid = 1'b0;
    drain();
  endtask

  task automatic load_hi(input logic [15:0] h);
    @(posedge clk); #1 hi_ld = 1'b1; base_half = h;
    @(posedge clk); #1 hi_ld = 1'b0;
    m_stage = h;
  endtask

  task automatic load_lo(input logic [15:0] l);
    @(posedge clk); #1 lo_ld = 1'b1; base_half = l;
    @(posedge clk); #1 lo_ld = 1'b0;
    m_hi = m_stage; m_lo = l; m_off = 0; m_armed = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check(req_ready == 1, "R12", "req_ready", {63'd0, req_ready}, 64'd1);
    check(wr_valid == 0, "R12", "wr_valid", {63'd0, wr_valid}, 64'd0);
    check(irq_req == 0, "R12", "irq_req", {63'd0, irq_req}, 64'd0);
    check(armed == 0, "R12", "armed", {63'd0, armed}, 64'd0);

    // R6 unarmed: request accepted, nothing written
    send_reply(24'h111111);
    repeat (5) @(negedge clk);
    check(writes_seen == 0, "R6", "writes while unarmed", 64'(writes_seen), 64'd0);

    // R1 staging the upper half alone does not arm or write
    load_hi(16'h1234);
    send_reply(24'h222222);
    repeat (5) @(negedge clk);
    check(writes_seen == 0, "R1", "writes after upper half only", 64'(writes_seen), 64'd0);
    check(armed == 0, "R6", "armed after upper half", {63'd0, armed}, 64'd0);

    // R2 R3 R7 commit and a few replies
    load_lo(16'h5000);
    @(negedge clk);
    check(armed == 1, "R6", "armed after commit", {63'd0, armed}, 64'd1);
    tag = "R2/R3/R7";
    for (int i = 0; i < 3; i++) send_reply(24'hA00000 + 24'(i));

    // R4 wrap under bus stalls
    stall_mode = 1; tag = "R4";
    for (int i = 0; i < 15; i++) send_reply(24'hB00000 + 24'(i));
    stall_mode = 0;

    // R1 new upper half staged only: next reply still on old base
    tag = "R1";
    load_hi(16'hABCD);
    send_reply(24'hC00001);

    // R2 R5 reload with low-half carry
    load_lo(16'hFFC0);
    tag = "R5";
    for (int i = 0; i < 17; i++) send_reply(24'hD00000 + 24'(i));

    // R9 interrupt
    irq_en = 1'b1; tag = "R9";
    send_reply(24'hE00001);
    @(negedge clk);
    check(irq_req == 1, "R9", "irq_req after reply", {63'd0, irq_req}, 64'd1);
    check(irq_vec == 8'hF0, "R9", "irq_vec", 64'(irq_vec), 64'hF0);
    check(irq_level == 3'd5, "R9", "irq_level", 64'(irq_level), 64'd5);
    repeat (4) @(negedge clk);
    check(irq_req == 1, "R9", "irq_req held", {63'd0, irq_req}, 64'd1);
    @(posedge clk); #1 irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
    @(negedge clk);
    check(irq_req == 0, "R9", "irq_req after ack", {63'd0, irq_req}, 64'd0);

    // R10 no interrupt when option off
    irq_en = 1'b0; tag = "R10";
    send_reply(24'hE00002);
    repeat (3) @(negedge clk);
    check(irq_req == 0, "R10", "irq_req with option off", {63'd0, irq_req}, 64'd0);

    // R11 commit and accept in the same cycle
    load_hi(16'h0042);
    tag = "R11";
    @(negedge clk);
    @(posedge clk); #1;
    lo_ld = 1'b1; base_half = 16'h0100; req_valid = 1'b1; req_payload = 24'hF00001;
    m_hi = m_stage; m_lo = 16'h0100; m_off = 0; m_armed = 1;
    push_expected(24'hF00001);
    @(posedge clk); #1 lo_ld = 1'b0; req_valid = 1'b0;
    drain();
    send_reply(24'hF00002);

    drain();
    check(exp_q.size() == 0, "R7", "scoreboard empty", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule